// File: doc/BRIEF.md
# Peripheral-to-Memory Byte Mover with Source Rewind

This block is a single DMA channel. It copies bytes from a peripheral data register into on-chip memory. Software sets a source start address, a destination address, a transfer count and a few control bits through a small register-write port, and then enables the channel. Each transfer reads one byte from the current source address and, in the next cycle, writes that byte to the current destination address.

A peripheral asks for data with a request input. The channel then raises a bus request and waits for a grant before it starts any bus cycle. In burst mode it keeps the bus for back-to-back transfers. In single mode it hands the bus back after every byte. An optional rewind mode moves the source pointer back to its programmed start after every fourth transfer and parks the channel there until the next peripheral request. The destination pointer keeps climbing through these rewinds.

When the last counted byte is written, the channel sets a sticky end flag and pulses an interrupt line. While the end flag is set, the channel accepts no new request.

Top module: `dma_reload_chan`

## Requirements
- R1: After reset, bus_req, mem_rd, mem_wr, irq and xfer_done are low, and the channel is disabled with all counters at zero.
- R2: A write with cfg_we selects a register by cfg_sel. A value of 0 selects the source start address, which also resets the group position. A value of 1 selects the destination address. A value of 2 selects the count, taken from the low CW bits. A value of 3 selects control: bit 0 enables the channel, bit 1 turns on rewind, bit 2 turns on burst, and bit 3 written as 1 clears the end flag. Writes to selections 0, 1 and 2 are ignored while bus_req is high.
- R3: No read cycle starts unless bus_gnt was high in the cycle before. Each transfer is one cycle with mem_rd at the source address, followed directly by one cycle with mem_wr at the destination address that carries the byte read.
- R4: Each completed transfer advances the destination address by 1 and lowers the remaining count by 1.
- R5: With rewind on, the source address steps by 1 within a group of four transfers and returns to the programmed start after the fourth.
- R6: With rewind off, the source address steps by 1 after every transfer and never wraps back.
- R7: With rewind on, the channel goes idle after the fourth transfer of each group and drops bus_req. It continues only on a new request.
- R8: In burst mode, one request gives back-to-back transfers: the next read follows the write directly, with bus_req held. In single mode, each request gives exactly one transfer.
- R9: When the count reaches zero, xfer_done is set and irq pulses for exactly one cycle, both in the cycle after the final write, and bus_req is low.
- R10: A request is ignored while xfer_done is set, while the count is zero, or while the channel is disabled.
- R11: Clearing the enable bit stops the channel. While it waits for a grant it stops at once. During a transfer it stops after that transfer's write. No further bus cycles follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | AW | Register write data |
| xfer_req | input | 1 | Peripheral transfer request |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus ownership grant |
| mem_addr | output | AW | Bus address |
| mem_rd | output | 1 | Single-cycle read strobe |
| mem_wr | output | 1 | Single-cycle write strobe |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid in the read cycle |
| irq | output | 1 | One-cycle end-of-count interrupt |
| xfer_done | output | 1 | Sticky end-of-count flag |

## Verification
Two events can land on the same write cycle: the final counted transfer and the fourth transfer of a rewind group. In that cycle the source pointer must rewind and the end flag must be set at the same time. The bench provokes this with counts that are multiples of four under rewind mode. It first checks the interrupt pulse, and that the request which follows is ignored. It then clears the flag, programs a fresh count without rewriting the source, and checks that the next read goes to the start address while the destination continues from where it stopped. Counts that end partway through a group are chained the same way, to show that the group phase carries across the two runs.

// File: rtl/dma_rl_pkg.sv
package dma_rl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_READ,
        ST_WRITE
    } chan_state_t;

    typedef struct packed {
        logic enable;
        logic rewind;
        logic burst;
    } chan_ctrl_t;

    localparam logic [1:0] SEL_SRC  = 2'd0;
    localparam logic [1:0] SEL_DST  = 2'd1;
    localparam logic [1:0] SEL_CNT  = 2'd2;
    localparam logic [1:0] SEL_CTRL = 2'd3;

    localparam int CTL_EN     = 0;
    localparam int CTL_REWIND = 1;
    localparam int CTL_BURST  = 2;
    localparam int CTL_CLR    = 3;

endpackage

// File: rtl/dma_rl_regs.sv
module dma_rl_regs
    import dma_rl_pkg::*;
#(
    parameter int AW    = 16,
    parameter int CW    = 12,
    parameter int GROUP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    input  logic          busy,
    input  logic          advance,
    output chan_ctrl_t    ctrl,
    output logic [AW-1:0] src_addr,
    output logic [AW-1:0] dst_addr,
    output logic          cnt_zero,
    output logic          cnt_last,
    output logic          grp_last,
    output logic          done,
    output logic          irq
);

    localparam int GW = (GROUP > 1) ? $clog2(GROUP) : 1;
    localparam logic [GW-1:0] GRP_END = GW'(GROUP - 1);

    typedef struct packed {
        logic [AW-1:0] src_start;
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [CW-1:0] cnt;
        logic [GW-1:0] grp;
        chan_ctrl_t    ctrl;
        logic          done;
        logic          irq;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        r_d.irq = 1'b0;

        if (cfg_we) begin
            case (cfg_sel)
                SEL_SRC: begin
                    if (!busy) begin
                        r_d.src_start = cfg_wdata;
                        r_d.src       = cfg_wdata;
                        r_d.grp       = '0;
                    end
                end
                SEL_DST: begin
                    if (!busy) r_d.dst = cfg_wdata;
                end
                SEL_CNT: begin
                    if (!busy) r_d.cnt = cfg_wdata[CW-1:0];
                end
                default: begin
                    r_d.ctrl.enable = cfg_wdata[CTL_EN];
                    r_d.ctrl.rewind = cfg_wdata[CTL_REWIND];
                    r_d.ctrl.burst  = cfg_wdata[CTL_BURST];
                    if (cfg_wdata[CTL_CLR]) r_d.done = 1'b0;
                end
            endcase
        end

        if (advance) begin
            r_d.dst = r_q.dst + AW'(1);
            r_d.cnt = r_q.cnt - CW'(1);
            if (r_q.grp == GRP_END) begin
                r_d.grp = '0;
                r_d.src = r_q.ctrl.rewind ? r_q.src_start : r_q.src + AW'(1);
            end else begin
                r_d.grp = r_q.grp + GW'(1);
                r_d.src = r_q.src + AW'(1);
            end
            if (r_q.cnt == CW'(1)) begin
                r_d.done = 1'b1;
                r_d.irq  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ctrl     = r_q.ctrl;
    assign src_addr = r_q.src;
    assign dst_addr = r_q.dst;
    assign cnt_zero = (r_q.cnt == '0);
    assign cnt_last = (r_q.cnt == CW'(1));
    assign grp_last = (r_q.grp == GRP_END);
    assign done     = r_q.done;
    assign irq      = r_q.irq;

endmodule

// File: rtl/dma_rl_seq.sv
module dma_rl_seq
    import dma_rl_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          xfer_req,
    input  logic          bus_gnt,
    input  chan_ctrl_t    ctrl,
    input  logic          done,
    input  logic          cnt_zero,
    input  logic          cnt_last,
    input  logic          grp_last,
    input  logic [DW-1:0] rdata,
    output logic          bus_req,
    output logic          rd,
    output logic          wr,
    output logic          advance,
    output logic [DW-1:0] wdata
);

    typedef struct packed {
        chan_state_t   state;
        logic [DW-1:0] hold;
    } seq_t;

    seq_t s_d, s_q;
    logic stop_after_wr;

    always_comb begin
        s_d = s_q;
        stop_after_wr = cnt_last || !ctrl.enable || !ctrl.burst
                        || (ctrl.rewind && grp_last);

        case (s_q.state)
            ST_IDLE: begin
                if (xfer_req && ctrl.enable && !done && !cnt_zero)
                    s_d.state = ST_WAIT;
            end
            ST_WAIT: begin
                if (!ctrl.enable)  s_d.state = ST_IDLE;
                else if (bus_gnt)  s_d.state = ST_READ;
            end
            ST_READ: begin
                s_d.hold  = rdata;
                s_d.state = ST_WRITE;
            end
            default: begin
                if (stop_after_wr) s_d.state = ST_IDLE;
                else if (bus_gnt)  s_d.state = ST_READ;
                else               s_d.state = ST_WAIT;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{state: ST_IDLE, hold: '0};
        else        s_q <= s_d;
    end

    assign bus_req = (s_q.state != ST_IDLE);
    assign rd      = (s_q.state == ST_READ);
    assign wr      = (s_q.state == ST_WRITE);
    assign advance = wr;
    assign wdata   = s_q.hold;

endmodule

// File: rtl/dma_reload_chan.sv
module dma_reload_chan
    import dma_rl_pkg::*;
#(
    parameter int AW    = 16,
    parameter int DW    = 8,
    parameter int CW    = 12,
    parameter int GROUP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    input  logic          xfer_req,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          irq,
    output logic          xfer_done
);

    chan_ctrl_t    ctrl;
    logic [AW-1:0] src_addr, dst_addr;
    logic          cnt_zero, cnt_last, grp_last, advance;

    dma_rl_regs #(.AW(AW), .CW(CW), .GROUP(GROUP)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_sel  (cfg_sel),
        .cfg_wdata(cfg_wdata),
        .busy     (bus_req),
        .advance  (advance),
        .ctrl     (ctrl),
        .src_addr (src_addr),
        .dst_addr (dst_addr),
        .cnt_zero (cnt_zero),
        .cnt_last (cnt_last),
        .grp_last (grp_last),
        .done     (xfer_done),
        .irq      (irq)
    );

    dma_rl_seq #(.DW(DW)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .xfer_req(xfer_req),
        .bus_gnt (bus_gnt),
        .ctrl    (ctrl),
        .done    (xfer_done),
        .cnt_zero(cnt_zero),
        .cnt_last(cnt_last),
        .grp_last(grp_last),
        .rdata   (mem_rdata),
        .bus_req (bus_req),
        .rd      (mem_rd),
        .wr      (mem_wr),
        .advance (advance),
        .wdata   (mem_wdata)
    );

    assign mem_addr = mem_wr ? dst_addr : src_addr;

endmodule

// File: rtl/dma_rl_checker.sv
module dma_rl_checker #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_we,
    input logic [1:0]    cfg_sel,
    input logic          bus_req,
    input logic          bus_gnt,
    input logic [AW-1:0] mem_addr,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic          irq,
    input logic          xfer_done
);

    logic          seen_q;
    logic [AW-1:0] last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            last_q <= '0;
        end else if (cfg_we && cfg_sel == 2'd1 && !bus_req) begin
            seen_q <= 1'b0;
        end else if (mem_wr) begin
            seen_q <= 1'b1;
            last_q <= mem_addr;
        end
    end

    p_rd_needs_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> $past(bus_gnt));

    p_wr_follows_rd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> mem_wr);

    p_rd_wr_apart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    p_dst_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && seen_q) |-> (mem_addr == AW'(last_q + 1'b1)));

    p_irq_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    p_irq_after_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(mem_wr));

    p_irq_with_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (xfer_done && !bus_req));

    p_idle_when_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> !mem_rd);

endmodule

bind dma_reload_chan dma_rl_checker #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_sel  (cfg_sel),
    .bus_req  (bus_req),
    .bus_gnt  (bus_gnt),
    .mem_addr (mem_addr),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .irq      (irq),
    .xfer_done(xfer_done)
);

// File: tb/dma_reload_chan_test.sv
`timescale 1ns/1ps
module dma_reload_chan_test;

    localparam logic [15:0] S = 16'h8408;
    localparam logic [15:0] D = 16'hF000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [15:0] cfg_wdata = '0;
    logic        xfer_req = 1'b0;
    logic        bus_req, bus_gnt, mem_rd, mem_wr, irq, xfer_done;
    logic        gnt_en = 1'b1;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    function automatic logic [7:0] pat(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    assign mem_rdata = pat(mem_addr);
    assign bus_gnt   = bus_req & gnt_en;

    dma_reload_chan uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .xfer_req(xfer_req), .bus_req(bus_req),
        .bus_gnt(bus_gnt), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .irq(irq), .xfer_done(xfer_done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic cfg(input logic [1:0] sel, input logic [15:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic logic [15:0] ctl(input bit rl, input bit bu);
        return 16'h0009 | (bu ? 16'h0004 : 16'h0) | (rl ? 16'h0002 : 16'h0);
    endfunction

    task automatic run_case(input bit rl, input bit bu, input int cnt,
                            input bit fresh, input int k0);
        int k = 0, reqs = 0, irqs = 0, cyc = 0, exp_reqs;
        int bad = 0;
        logic [15:0] esrc;
        if (fresh) begin
            cfg(2'd0, S);
            cfg(2'd1, D);
        end
        cfg(2'd2, 16'(cnt));
        cfg(2'd3, ctl(rl, bu));
        while (!xfer_done && cyc < 3000) begin
            @(negedge clk);
            cyc++;
            esrc = rl ? S + 16'((k0 + k) % 4) : S + 16'(k0 + k);
            if (mem_rd) chk(rl ? "R5 src" : "R6 src", {16'h0, mem_addr}, {16'h0, esrc});
            if (mem_wr) begin
                chk("R4 dst", {16'h0, mem_addr}, {16'h0, D + 16'(k0 + k)});
                chk("R3 data", {24'h0, mem_wdata}, {24'h0, pat(esrc)});
                k++;
            end
            if (irq) irqs++;
            if (xfer_req) xfer_req = 1'b0;
            else if (!bus_req && !xfer_done && k < cnt) begin
                xfer_req = 1'b1;
                reqs++;
            end
        end
        exp_reqs = bu ? (rl ? ((k0 % 4) + cnt + 3) / 4 : 1) : cnt;
        @(negedge clk);
        chk("R9 irq one cycle", {31'h0, irq}, 32'h0);
        chk("R9 bus released", {31'h0, bus_req}, 32'h0);
        chk("R9 flag", {31'h0, xfer_done}, 32'h1);
        chk("R9 irq count", 32'(irqs), 32'h1);
        chk("R4 transfers", 32'(k), 32'(cnt));
        chk(rl ? "R7 requests" : "R8 requests", 32'(reqs), 32'(exp_reqs));
        xfer_req = 1'b1;
        @(negedge clk);
        xfer_req = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (mem_rd || bus_req) bad++;
        end
        chk("R10 ignored when done", 32'(bad), 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL R1 watchdog: got 1 expected 0");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int n, bad;
        repeat (3) @(negedge clk);
        chk("R1 bus_req", {31'h0, bus_req}, 32'h0);
        chk("R1 rd/wr", {30'h0, mem_rd, mem_wr}, 32'h0);
        chk("R1 irq/flag", {30'h0, irq, xfer_done}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: disabled channel ignores a request
        xfer_req = 1'b1; @(negedge clk); xfer_req = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 disabled", {31'h0, bus_req}, 32'h0);

        for (int rl = 0; rl < 2; rl++)
            for (int bu = 0; bu < 2; bu++)
                foreach (n_list[i]) run_case(rl[0], bu[0], n_list[i], 1'b1, 0);

        // group end coincides with last count; then continue without rewriting source
        run_case(1'b1, 1'b1, 8, 1'b1, 0);
        run_case(1'b1, 1'b1, 2, 1'b0, 8);
        run_case(1'b1, 1'b0, 5, 1'b1, 0);
        run_case(1'b1, 1'b1, 3, 1'b0, 5);
        run_case(1'b0, 1'b1, 4, 1'b1, 0);
        run_case(1'b0, 1'b1, 3, 1'b0, 4);

        // R10: zero count ignores request
        cfg(2'd2, 16'h0);
        cfg(2'd3, 16'h0009);
        xfer_req = 1'b1; @(negedge clk); xfer_req = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 zero count", {31'h0, bus_req}, 32'h0);

        // R2 / R3: grant withheld, writes while busy are ignored
        cfg(2'd0, S); cfg(2'd1, D); cfg(2'd2, 16'd2); cfg(2'd3, 16'h000D);
        gnt_en = 1'b0;
        xfer_req = 1'b1; @(negedge clk); xfer_req = 1'b0;
        bad = 0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (mem_rd || !bus_req) bad++;
        end
        chk("R3 waits for grant", 32'(bad), 32'h0);
        cfg(2'd1, 16'h1234);
        cfg(2'd2, 16'd9);
        gnt_en = 1'b1;
        n = 0; bad = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (mem_wr) begin
                if (mem_addr != D + 16'(n)) bad++;
                n++;
            end
        end
        chk("R2 busy writes ignored addr", 32'(bad), 32'h0);
        chk("R2 busy writes ignored count", 32'(n), 32'd2);
        chk("R9 flag after busy test", {31'h0, xfer_done}, 32'h1);

        // R11: abort while waiting for grant
        cfg(2'd0, S); cfg(2'd1, D); cfg(2'd2, 16'd4); cfg(2'd3, 16'h000D);
        gnt_en = 1'b0;
        xfer_req = 1'b1; @(negedge clk); xfer_req = 1'b0;
        repeat (2) @(negedge clk);
        cfg(2'd3, 16'h0000);
        @(negedge clk);
        chk("R11 abort in wait", {31'h0, bus_req}, 32'h0);
        gnt_en = 1'b1;
        bad = 0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (mem_rd) bad++;
        end
        chk("R11 no cycles after abort", 32'(bad), 32'h0);

        // R11: abort in the middle of a burst
        cfg(2'd2, 16'd8); cfg(2'd3, 16'h000D);
        xfer_req = 1'b1; @(negedge clk); xfer_req = 1'b0;
        n = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (cfg_we) cfg_we = 1'b0;
            if (mem_wr) begin
                n++;
                if (n == 2) begin
                    cfg_we = 1'b1; cfg_sel = 2'd3; cfg_wdata = 16'h0000;
                end
            end
        end
        chk("R11 burst abort count", 32'(n), 32'd3);
        chk("R11 burst abort bus", {31'h0, bus_req}, 32'h0);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    int n_list[9] = '{1, 2, 3, 4, 5, 7, 8, 9, 12};

endmodule